// File: doc/BRIEF.md
# Descriptor Chain Walker

This block automates a series of memory-to-memory copies by walking a linked list of transfer descriptors held in memory. Software first loads the address of the first descriptor into the live-pointer register, then writes the address of the last descriptor into the end-pointer register. That second write starts the walk. For each descriptor the block fetches the link, source, destination and length words over a single-word memory port. It then hands one copy request to a separate data mover and waits for that mover's completion. It marks the descriptor finished by writing its status word, and then moves on to the descriptor named by the link.

In normal operation the walk ends once the descriptor at the end-pointer address has been finished, and the block then reports idle. In cyclic mode the end pointer is never treated as a stop point, so a chain whose last link points back to its head is processed over and over. The walk ends only when scatter-gather operation is switched off or the block is reset. A failed memory access or a failed copy halts the walk and raises an error flag. The live pointer is left on the descriptor that failed.

Descriptors are 64 bytes long and sit on 64-byte boundaries. The word offsets within a descriptor are: byte 0 holds the link, byte 8 the source address, byte 16 the destination address, byte 24 the length, and byte 28 the status word.

Top module: `sg_chain_walker`

## Requirements
- R1: The live-pointer and end-pointer registers always read with bits 5:0 equal to zero. Values written to those bits are dropped.
- R2: A pulse on `tail_wr` starts a walk only when the block is idle, `sg_enable` is 1 and no error flag is set. In that case `idle` reads 0 one cycle later. A `cur_wr` pulse while a walk is running has no effect.
- R3: For each descriptor the block issues memory reads at offsets 0, 8, 16 and 24 from the descriptor address, one at a time, in that order. Each read waits for its response before the next is issued.
- R4: The block issues exactly one copy request per descriptor. The request carries the source word, the destination word and bits 22:0 of the length word. It is held stable until `cmd_ready` accepts it.
- R5: After `done_valid`, the block writes the status word at offset 28 with bit 31 = 1 (complete), bit 30 = the copy error, and all other bits 0.
- R6: While a walk runs, `cur_ptr` equals the address of the descriptor whose copy is in progress. After each status write the block follows the link word.
- R7: Without cyclic mode, the walk ends after the status write of the descriptor whose address equals the end pointer, and `idle` returns to 1.
- R8: With `cyclic_en` = 1 the end pointer never stops the walk, and a looped chain is processed repeatedly.
- R9: A memory response with `mem_rsp_err` = 1 halts the walk. It sets `err_mem`, sets `idle` to 1, and leaves `cur_ptr` on the descriptor being accessed. Further `tail_wr` pulses do not restart the walk.
- R10: A copy that completes with `done_err` = 1 gets its status word written with bits 31 and 30 set. The walk then halts with `err_copy` = 1 and `cur_ptr` on that descriptor.
- R11: While `sg_enable` = 0 the live pointer is cleared, both error flags are cleared and any walk is abandoned, so `idle` = 1.
- R12: An end-pointer write during a walk updates the stop point, so a running chain can be extended.
- R13: A memory request is held with a stable address until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sg_enable | input | 1 | Scatter-gather operation enabled |
| cyclic_en | input | 1 | Ignore the end pointer and loop forever |
| cur_wr | input | 1 | Write strobe for the live pointer |
| tail_wr | input | 1 | Write strobe for the end pointer; starts a walk |
| host_wdata | input | ADDR_W | Value for either pointer write |
| cur_ptr | output | ADDR_W | Live descriptor pointer |
| tail_ptr | output | ADDR_W | End descriptor pointer |
| idle | output | 1 | No walk in progress |
| err_mem | output | 1 | Halted on a memory error |
| err_copy | output | 1 | Halted on a copy error |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Access failed |
| cmd_valid | output | 1 | Copy request valid |
| cmd_ready | input | 1 | Copy request accepted |
| cmd_src | output | ADDR_W | Copy source address |
| cmd_dst | output | ADDR_W | Copy destination address |
| cmd_len | output | LEN_W | Copy length in bytes |
| done_valid | input | 1 | Copy finished |
| done_err | input | 1 | Copy failed |

## Verification
The hardest situation to reach from the ports is an end-pointer write that lands while a walk is already in flight. That write must move the stop point without restarting or disturbing the walk. The bench starts a three-descriptor chain whose end pointer names the first descriptor. On the very next cycles it rewrites the end pointer to the third descriptor and throws a stray live-pointer write at the running block. All of this happens while the memory model is still answering the first descriptor's fetches. The halt cases are forced through the models: a link word that points outside the modelled memory triggers the memory error, and a length word of all ones makes the copy model report a failure.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int WORD_W = 32;

    // Byte offsets of the fields inside one descriptor
    localparam int STATUS_BYTE_OFS = 28;
    localparam int DONE_BIT        = 31;
    localparam int FAULT_BIT       = 30;
    localparam int FIELD_CNT       = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_CMD,
        ST_DONE,
        ST_WB_REQ,
        ST_WB_WAIT
    } walk_state_e;

endpackage

// File: rtl/sgw_ptr_regs.sv
module sgw_ptr_regs #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sg_enable,
    input  logic              idle,
    input  logic              cur_wr,
    input  logic              tail_wr,
    input  logic [ADDR_W-1:0] host_wdata,
    input  logic              adv_valid,
    input  logic [ADDR_W-1:0] adv_ptr,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [ADDR_W-1:0] tail_ptr
);

    localparam logic [ADDR_W-1:0] LOW_ONES   = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_ONES;

    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] tail;
    } ptr_state_t;

    ptr_state_t q, d;

    always_comb begin
        d = q;
        if (tail_wr) begin
            d.tail = host_wdata & ALIGN_MASK;
        end
        if (!sg_enable) begin
            d.cur = '0;
        end else if (adv_valid) begin
            d.cur = adv_ptr & ALIGN_MASK;
        end else if (cur_wr && idle) begin
            d.cur = host_wdata & ALIGN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_ptr  = q.cur;
    assign tail_ptr = q.tail;

    AST_CUR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ptr & LOW_ONES) == '0); // R1

    AST_TAIL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_ptr & LOW_ONES) == '0); // R1

    AST_SG_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !sg_enable |=> cur_ptr == '0); // R11

    AST_CUR_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !sg_enable)
        (!idle && !adv_valid) |=> $stable(cur_ptr)); // R2

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sg_enable,
    input  logic              cyclic_en,
    input  logic              tail_wr,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] tail_ptr,
    output logic              idle,
    output logic              err_mem,
    output logic              err_copy,
    output logic              adv_valid,
    output logic [ADDR_W-1:0] adv_ptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_src,
    output logic [ADDR_W-1:0] cmd_dst,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              done_valid,
    input  logic              done_err
);

    localparam int IDX_W = $clog2(FIELD_CNT);

    typedef struct packed {
        walk_state_e       st;
        logic [IDX_W-1:0]  widx;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic              cperr;
        logic              emem;
        logic              ecopy;
    } walk_t;

    walk_t q, d;

    logic [ADDR_W-1:0] rd_ofs;
    logic [ADDR_W-1:0] wb_ofs;
    logic              last_desc;

    assign rd_ofs    = ADDR_W'({q.widx, 3'b000});
    assign wb_ofs    = ADDR_W'(STATUS_BYTE_OFS);
    assign last_desc = !cyclic_en && (cur_ptr == tail_ptr);

    always_comb begin
        d         = q;
        adv_valid = 1'b0;
        adv_ptr   = q.nxt;
        if (!sg_enable) begin
            d.st    = ST_IDLE;
            d.emem  = 1'b0;
            d.ecopy = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (tail_wr && !q.emem && !q.ecopy) begin
                        d.st   = ST_RD_REQ;
                        d.widx = '0;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready) d.st = ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            d.emem = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            unique case (q.widx)
                                2'd0:    d.nxt = ADDR_W'(mem_rsp_data);
                                2'd1:    d.src = ADDR_W'(mem_rsp_data);
                                2'd2:    d.dst = ADDR_W'(mem_rsp_data);
                                default: d.len = mem_rsp_data[LEN_W-1:0];
                            endcase
                            if (q.widx == IDX_W'(FIELD_CNT - 1)) begin
                                d.st = ST_CMD;
                            end else begin
                                d.widx = q.widx + 1'b1;
                                d.st   = ST_RD_REQ;
                            end
                        end
                    end
                end
                ST_CMD: begin
                    if (cmd_ready) d.st = ST_DONE;
                end
                ST_DONE: begin
                    if (done_valid) begin
                        d.cperr = done_err;
                        d.st    = ST_WB_REQ;
                    end
                end
                ST_WB_REQ: begin
                    if (mem_req_ready) d.st = ST_WB_WAIT;
                end
                ST_WB_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            d.emem = 1'b1;
                            d.st   = ST_IDLE;
                        end else if (q.cperr) begin
                            d.ecopy = 1'b1;
                            d.st    = ST_IDLE;
                        end else if (last_desc) begin
                            d.st = ST_IDLE;
                        end else begin
                            adv_valid = 1'b1;
                            d.widx    = '0;
                            d.st      = ST_RD_REQ;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign idle          = (q.st == ST_IDLE);
    assign err_mem       = q.emem;
    assign err_copy      = q.ecopy;
    assign mem_req_valid = (q.st == ST_RD_REQ) || (q.st == ST_WB_REQ);
    assign mem_req_write = (q.st == ST_WB_REQ);
    assign mem_req_addr  = cur_ptr + (mem_req_write ? wb_ofs : rd_ofs);
    assign mem_req_wdata = {1'b1, q.cperr, {(WORD_W-2){1'b0}}};
    assign cmd_valid     = (q.st == ST_CMD);
    assign cmd_src       = q.src;
    assign cmd_dst       = q.dst;
    assign cmd_len       = q.len;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || !sg_enable)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R13

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n || !sg_enable)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_len))); // R4

    AST_START_NEEDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> ($past(tail_wr) && $past(sg_enable))); // R2

    AST_STOP_AT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle) && sg_enable && $past(sg_enable) && !err_mem && !err_copy)
        |-> ($past(cur_ptr == tail_ptr) && !$past(cyclic_en))); // R7

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mem || err_copy) |-> idle); // R9

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 23,
    parameter int ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sg_enable,
    input  logic              cyclic_en,
    input  logic              cur_wr,
    input  logic              tail_wr,
    input  logic [ADDR_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [ADDR_W-1:0] tail_ptr,
    output logic              idle,
    output logic              err_mem,
    output logic              err_copy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_src,
    output logic [ADDR_W-1:0] cmd_dst,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              done_valid,
    input  logic              done_err
);

    logic              adv_valid;
    logic [ADDR_W-1:0] adv_ptr;

    sgw_ptr_regs #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sg_enable  (sg_enable),
        .idle       (idle),
        .cur_wr     (cur_wr),
        .tail_wr    (tail_wr),
        .host_wdata (host_wdata),
        .adv_valid  (adv_valid),
        .adv_ptr    (adv_ptr),
        .cur_ptr    (cur_ptr),
        .tail_ptr   (tail_ptr)
    );

    sgw_walker #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .sg_enable     (sg_enable),
        .cyclic_en     (cyclic_en),
        .tail_wr       (tail_wr),
        .cur_ptr       (cur_ptr),
        .tail_ptr      (tail_ptr),
        .idle          (idle),
        .err_mem       (err_mem),
        .err_copy      (err_copy),
        .adv_valid     (adv_valid),
        .adv_ptr       (adv_ptr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_src       (cmd_src),
        .cmd_dst       (cmd_dst),
        .cmd_len       (cmd_len),
        .done_valid    (done_valid),
        .done_err      (done_err)
    );

endmodule

// File: tb/sg_chain_walker_bench.sv
`timescale 1ns/1ps
module sg_chain_walker_bench;

    localparam int AW = 32;
    localparam int LW = 23;
    localparam int MEM_WORDS = 256;
    localparam int MEM_BYTES = MEM_WORDS * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sg_enable = 1'b0, cyclic_en = 1'b0, cur_wr = 1'b0, tail_wr = 1'b0;
    logic [AW-1:0] host_wdata = '0;
    logic [AW-1:0] cur_ptr, tail_ptr;
    logic          idle, err_mem, err_copy;
    logic          mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [31:0]   mem_req_wdata;
    logic          mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          cmd_valid, cmd_ready = 1'b0;
    logic [AW-1:0] cmd_src, cmd_dst;
    logic [LW-1:0] cmd_len;
    logic          done_valid = 1'b0, done_err = 1'b0;

    always #2.5 clk = ~clk;

    sg_chain_walker u_sg_chain_walker (
        .clk(clk), .rst_n(rst_n), .sg_enable(sg_enable), .cyclic_en(cyclic_en),
        .cur_wr(cur_wr), .tail_wr(tail_wr), .host_wdata(host_wdata),
        .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .idle(idle),
        .err_mem(err_mem), .err_copy(err_copy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_len(cmd_len),
        .done_valid(done_valid), .done_err(done_err)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    logic [31:0] mem [0:MEM_WORDS-1];
    logic [AW-1:0] daddr [0:7];

    // logs filled by the models
    int            cmd_n = 0;
    logic [AW-1:0] log_src [0:63];
    logic [AW-1:0] log_dst [0:63];
    logic [LW-1:0] log_len [0:63];
    logic [AW-1:0] log_cur [0:63];
    int            rd_n = 0;
    logic [AW-1:0] log_rd [0:63];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: one outstanding access, response one or two cycles later
    int mpat = 0;
    int rsp_cnt = 0;
    logic [31:0] rsp_d;
    logic rsp_e;
    always @(negedge clk) begin
        int idx;
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_d;
                mem_rsp_err   = rsp_e;
            end
        end
        mpat++;
        mem_req_ready = rst_n && ((mpat % 3) != 1);
        if (mem_req_valid && mem_req_ready) begin
            idx   = int'(mem_req_addr[9:2]);
            rsp_e = (mem_req_addr >= AW'(MEM_BYTES));
            rsp_d = 32'h0;
            if (!rsp_e) begin
                if (mem_req_write) mem[idx] = mem_req_wdata;
                else rsp_d = mem[idx];
            end
            if (!mem_req_write && rd_n < 64) begin
                log_rd[rd_n] = mem_req_addr;
                rd_n++;
            end
            rsp_cnt = 1 + (mpat % 2);
        end
    end

    // copy model: failure when the length is all ones
    int cpat = 0;
    int done_cnt = 0;
    logic done_e;
    always @(negedge clk) begin
        done_valid = 1'b0;
        done_err   = 1'b0;
        if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) begin
                done_valid = 1'b1;
                done_err   = done_e;
            end
        end
        cpat++;
        cmd_ready = rst_n && ((cpat % 4) != 0);
        if (cmd_valid && cmd_ready) begin
            if (cmd_n < 64) begin
                log_src[cmd_n] = cmd_src;
                log_dst[cmd_n] = cmd_dst;
                log_len[cmd_n] = cmd_len;
                log_cur[cmd_n] = cur_ptr;
            end
            cmd_n++;
            done_e   = (cmd_len == {LW{1'b1}});
            done_cnt = 2;
        end
    end

    function automatic logic [31:0] exp_src(input int i, input int n);
        return 32'h1000_0000 + 32'(i) * 32'h100 + 32'(n);
    endfunction
    function automatic logic [31:0] exp_dst(input int i, input int n);
        return 32'h2000_0000 + 32'(i) * 32'h40 + 32'(n) * 4;
    endfunction
    function automatic logic [LW-1:0] exp_len(input int i, input int n);
        return LW'(i * 7 + n + 1);
    endfunction

    task automatic setup_chain(input int n, input int s0, input int step, input bit loop_back);
        for (int w = 0; w < MEM_WORDS; w++) mem[w] = 32'h0;
        for (int i = 0; i < n; i++) daddr[i] = AW'(((s0 + i * step) % 16) * 64);
        for (int i = 0; i < n; i++) begin
            int b;
            b = int'(daddr[i] >> 2);
            if (i < n - 1)   mem[b] = daddr[i + 1];
            else if (loop_back) mem[b] = daddr[0];
            else             mem[b] = (daddr[i] + 32'd64) % MEM_BYTES;
            mem[b + 1] = 32'hDEAD_0001;
            mem[b + 2] = exp_src(i, n);
            mem[b + 3] = 32'hDEAD_0003;
            mem[b + 4] = exp_dst(i, n);
            mem[b + 5] = 32'hDEAD_0005;
            mem[b + 6] = 32'hFF80_0000 | 32'(exp_len(i, n));
            mem[b + 7] = 32'h0;
        end
        cmd_n = 0;
        rd_n  = 0;
    endtask

    task automatic wr_cur(input logic [AW-1:0] v);
        @(negedge clk); cur_wr = 1'b1; host_wdata = v;
        @(negedge clk); cur_wr = 1'b0;
    endtask
    task automatic wr_tail(input logic [AW-1:0] v);
        @(negedge clk); tail_wr = 1'b1; host_wdata = v;
        @(negedge clk); tail_wr = 1'b0;
    endtask
    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3000; k++) begin
            if (idle) break;
            @(negedge clk);
        end
    endtask
    task automatic quiesce();
        @(negedge clk); sg_enable = 1'b0;
        repeat (10) @(negedge clk);
        sg_enable = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] status_of(input logic [AW-1:0] a);
        return mem[int'(a >> 2) + 7];
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R11 reset idle", 32'(idle), 32'd1);
        chk("R1 reset cur", cur_ptr, 32'h0);
        chk("R1 reset tail", tail_ptr, 32'h0);
        chk("R9 reset errors", {30'd0, err_mem, err_copy}, 32'h0);
        chk("R13 reset no request", {30'd0, mem_req_valid, cmd_valid}, 32'h0);

        // R2: start ignored while scatter-gather is off
        setup_chain(1, 0, 1, 0);
        wr_tail(32'h0);
        repeat (3) @(negedge clk);
        chk("R2 tail write with sg off keeps idle", 32'(idle), 32'd1);
        chk("R2 no command with sg off", 32'(cmd_n), 32'd0);

        sg_enable = 1'b1;
        // R1 masking of low bits
        wr_cur(32'h0000_017F);
        chk("R1 cur low bits dropped", cur_ptr, 32'h0000_0140);
        @(negedge clk); cur_wr = 1'b0;
        host_wdata = 32'h0000_03FF;
        @(negedge clk); host_wdata = 32'h0;
        wr_cur(32'h0);

        // sweep of chain lengths and placements, non-cyclic
        for (int n = 1; n <= 4; n++) begin
            for (int s0 = 0; s0 < 4; s0++) begin
                int step;
                step = (s0 % 2 == 1) ? 3 : 5;
                setup_chain(n, s0, step, 0);
                wr_cur(daddr[0] | 32'h15);
                wr_tail(daddr[n - 1] | 32'h2A);
                chk("R1 tail low bits dropped", tail_ptr, daddr[n - 1]);
                chk("R2 idle falls after tail write", 32'(idle), 32'd0);
                wait_idle();
                chk("R7 idle after tail descriptor", 32'(idle), 32'd1);
                chk("R4 one command per descriptor", 32'(cmd_n), 32'(n));
                chk("R3 read count", 32'(rd_n), 32'(4 * n));
                for (int i = 0; i < n; i++) begin
                    chk("R4 source", log_src[i], exp_src(i, n));
                    chk("R4 destination", log_dst[i], exp_dst(i, n));
                    chk("R4 length masked to 23 bits", 32'(log_len[i]), 32'(exp_len(i, n)));
                    chk("R6 live pointer during copy", log_cur[i], daddr[i]);
                    chk("R5 status complete", status_of(daddr[i]), 32'h8000_0000);
                    for (int f = 0; f < 4; f++)
                        chk("R3 read order", log_rd[4 * i + f], daddr[i] + 32'(8 * f));
                end
                chk("R7 live pointer stays on tail", cur_ptr, daddr[n - 1]);
                chk("R9 no errors", {30'd0, err_mem, err_copy}, 32'h0);
            end
        end

        // R12 and R2: extend a running chain; stray live-pointer write ignored
        setup_chain(3, 5, 2, 0);
        wr_cur(daddr[0]);
        wr_tail(daddr[0]);
        wr_tail(daddr[2]);
        wr_cur(32'h0000_03C0);
        chk("R2 live pointer write ignored while busy", cur_ptr, daddr[0]);
        wait_idle();
        chk("R12 extended chain runs to new tail", 32'(cmd_n), 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R12 source order", log_src[i], exp_src(i, 3));
            chk("R6 live pointer during copy", log_cur[i], daddr[i]);
        end
        chk("R12 stops on new tail", cur_ptr, daddr[2]);

        // R8 cyclic mode
        setup_chain(3, 2, 5, 1);
        cyclic_en = 1'b1;
        wr_cur(daddr[0]);
        wr_tail(daddr[0]);
        for (int k = 0; k < 3000; k++) begin
            if (cmd_n >= 7) break;
            @(negedge clk);
        end
        chk("R8 still running past tail", 32'(idle), 32'd0);
        chk("R8 seven commands reached", 32'(cmd_n >= 7), 32'd1);
        for (int k = 0; k < 7; k++) begin
            chk("R8 cyclic source order", log_src[k], exp_src(k % 3, 3));
            chk("R8 cyclic live pointer", log_cur[k], daddr[k % 3]);
        end
        @(negedge clk); sg_enable = 1'b0;
        @(negedge clk);
        chk("R11 sg off stops walk", 32'(idle), 32'd1);
        chk("R11 sg off clears live pointer", cur_ptr, 32'h0);
        cyclic_en = 1'b0;
        repeat (10) @(negedge clk);
        sg_enable = 1'b1;

        // R9 memory decode error on the link
        setup_chain(2, 1, 3, 0);
        mem[int'(daddr[0] >> 2)] = 32'h0000_4000;
        wr_cur(daddr[0]);
        wr_tail(32'h0000_4000);
        wait_idle();
        chk("R9 err_mem set", 32'(err_mem), 32'd1);
        chk("R9 err_copy clear", 32'(err_copy), 32'd0);
        chk("R9 pointer on failing descriptor", cur_ptr, 32'h0000_4000);
        chk("R9 one command", 32'(cmd_n), 32'd1);
        chk("R5 first status written", status_of(daddr[0]), 32'h8000_0000);
        wr_tail(daddr[0]);
        repeat (5) @(negedge clk);
        chk("R9 tail write ignored after error", 32'(idle), 32'd1);
        chk("R9 no new command after error", 32'(cmd_n), 32'd1);
        @(negedge clk); sg_enable = 1'b0;
        @(negedge clk);
        chk("R11 sg off clears err_mem", 32'(err_mem), 32'd0);
        repeat (10) @(negedge clk);
        sg_enable = 1'b1;

        // R10 copy error
        setup_chain(2, 3, 5, 0);
        mem[int'(daddr[0] >> 2) + 6] = 32'h007F_FFFF;
        wr_cur(daddr[0]);
        wr_tail(daddr[1]);
        wait_idle();
        chk("R10 err_copy set", 32'(err_copy), 32'd1);
        chk("R10 status with fault bit", status_of(daddr[0]), 32'hC000_0000);
        chk("R10 pointer on failing descriptor", cur_ptr, daddr[0]);
        chk("R10 one command", 32'(cmd_n), 32'd1);
        chk("R10 next descriptor untouched", status_of(daddr[1]), 32'h0);
        quiesce();
        chk("R11 sg off clears err_copy", 32'(err_copy), 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule